// File: doc/BRIEF.md
# Hierarchical PCIe Interrupt Aggregator

This block sits in a PCIe root port and collects every interrupt source into a single level interrupt line toward the CPU's interrupt controller. Two kinds of event come in. MSI write events carry a 16-bit vector. Core event pulses report power-management events, errors, the four legacy INTx wires, link loss and hot reset. The block latches all of them in a three-level status tree. The top level is a single summary. Below it sits a core register. Below the core register sits a 32-bit MSI register.

An MSI is folded into the MSI register by the low five bits of its vector. All vectors that share those five bits land in the same status bit and share one mask bit. Each level has status, mask and write-one-to-clear access through a simple single-cycle register port. A mask only stops a bit or a summary from propagating upward. The status behind the mask still latches and can be read. A global MSI enable decides whether MSI writes are accepted at all.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the status registers read 0. The MSI mask reads 0xFFFFFFFF, the core mask reads 0x1FF, the top mask reads 1, the control register reads 0 and irq_out is low.
- R2: An accepted MSI sets MSI status bit number msi_vector[4:0]. Vectors that differ only in bits 15:5 (for example 0x0004 and 0xFFE4) set the same bit, and no other bit is set.
- R3: While the MSI enable (bit 0 of the control register at offset 5) is 0, MSI events set no status bit.
- R4: A pulse on core_evt[k] sets core status bit k. The bit order is PME 0, error 1, INTA 2, INTB 3, INTC 4, INTD 5, link down 6, hot reset 7.
- R5: Writing a 1 to a status bit at offset 0 (MSI) or offset 2 (core) clears that bit, and writing a 0 leaves it unchanged. If a new event for a bit arrives in the same cycle as its clear, the bit stays set.
- R6: Core status bit 8 reads as the MSI summary, which is the OR of (MSI status AND NOT MSI mask).
- R7: irq_out is a level output. It equals the core summary AND NOT the top mask, where the core summary is the OR of (core status bits 8:0 AND NOT core mask bits 8:0).
- R8: Masks never stop status from latching. Masked bits still read back as set, and irq_out stays low while every path is masked.
- R9: Several pending sources (for example PME, error, INTB and MSI bits 4, 5 and 8) are all visible at once in the status reads.
- R10: The register offsets are 0 MSI status, 1 MSI mask, 2 core status, 3 core mask, 4 top mask (bit 0) and 5 control (bit 0). Other offsets read 0, and writes to them have no effect.
- R11: Core status bit 8 is read-only. Writing to it has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | One-cycle strobe for an incoming MSI write |
| msi_vector | input | 16 | Interrupt number carried by the MSI |
| core_evt | input | 8 | One-cycle pulses from the core event sources |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset for both reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, valid in the same cycle |
| irq_out | output | 1 | Level interrupt toward the CPU |

## Verification
A table of MSI vectors, including pairs that differ only in their upper eleven bits, is sent one at a time with all masks open. Each result shows whether folding picks exactly the bit named by the low five bits and whether the line follows. Directed cases then cover the following:
- Every core source is pulsed on its own, which shows that each source has a distinct bit position.
- MSIs are sent while the enable is off, which shows whether the global gate drops them.
- Events arrive behind closed masks, which separates latching from propagation.
- A clear lands in the same cycle as a fresh event for the same bit, which shows whether the set wins.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
  localparam int VEC_W    = 16;
  localparam int MSI_BITS = 32;
  localparam int SLOT_W   = $clog2(MSI_BITS);
  localparam int CORE_SRC = 8;
  localparam int CORE_W   = CORE_SRC + 1;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 32;

  typedef enum logic [ADDR_W-1:0] {
    OFS_MSI_STAT  = 4'd0,
    OFS_MSI_MASK  = 4'd1,
    OFS_CORE_STAT = 4'd2,
    OFS_CORE_MASK = 4'd3,
    OFS_TOP_MASK  = 4'd4,
    OFS_CTRL      = 4'd5
  } reg_ofs_e;

  // Any bit pending that its mask lets through.
  function automatic logic any_open(input logic [DATA_W-1:0] st,
                                    input logic [DATA_W-1:0] mk);
    return |(st & ~mk);
  endfunction

  // Next value of a write-one-to-clear status register; a set wins.
  function automatic logic [DATA_W-1:0] w1c_next(input logic [DATA_W-1:0] cur,
                                                 input logic [DATA_W-1:0] clr,
                                                 input logic [DATA_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/irqa_status_bank.sv
module irqa_status_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] status
);
  import irqa_pkg::*;

  logic [DATA_W-1:0] nxt_wide;
  assign nxt_wide = w1c_next(DATA_W'(status), DATA_W'(clr_vec), DATA_W'(set_vec));

  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= nxt_wide[W-1:0];
  end

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));
  // R5
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((status & $past(clr_vec) & ~$past(set_vec)) == '0));
  // R4
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(set_vec)) == '0));
endmodule

// File: rtl/irqa_msi_fold.sv
module irqa_msi_fold
  import irqa_pkg::*;
(
  input  logic                msi_valid,
  input  logic [SLOT_W-1:0]   slot,
  input  logic                msi_en,
  output logic [MSI_BITS-1:0] set_vec
);
  logic take;
  assign take = msi_valid & msi_en;

  for (genvar i = 0; i < MSI_BITS; i++) begin : g_slot
    assign set_vec[i] = take && (slot == SLOT_W'(i));
  end

  // R2
  fold_onehot_chk: assert final ($onehot0(set_vec));
endmodule

// File: rtl/irqa_regfile.sv
module irqa_regfile
  import irqa_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  input  logic [MSI_BITS-1:0] msi_status,
  input  logic [CORE_W-1:0]   core_view,
  output logic [MSI_BITS-1:0] msi_mask,
  output logic [CORE_W-1:0]   core_mask,
  output logic                top_mask,
  output logic                msi_en,
  output logic [MSI_BITS-1:0] msi_clr,
  output logic [CORE_SRC-1:0] core_clr,
  output logic [DATA_W-1:0]   reg_rdata
);
  logic hit_msi_stat, hit_msi_mask, hit_core_stat, hit_core_mask, hit_top, hit_ctrl;
  assign hit_msi_stat  = reg_wr && (reg_addr == OFS_MSI_STAT);
  assign hit_msi_mask  = reg_wr && (reg_addr == OFS_MSI_MASK);
  assign hit_core_stat = reg_wr && (reg_addr == OFS_CORE_STAT);
  assign hit_core_mask = reg_wr && (reg_addr == OFS_CORE_MASK);
  assign hit_top       = reg_wr && (reg_addr == OFS_TOP_MASK);
  assign hit_ctrl      = reg_wr && (reg_addr == OFS_CTRL);

  assign msi_clr  = hit_msi_stat  ? reg_wdata[MSI_BITS-1:0] : '0;
  assign core_clr = hit_core_stat ? reg_wdata[CORE_SRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msi_mask  <= '1;
      core_mask <= '1;
      top_mask  <= 1'b1;
      msi_en    <= 1'b0;
    end else begin
      if (hit_msi_mask)  msi_mask  <= reg_wdata[MSI_BITS-1:0];
      if (hit_core_mask) core_mask <= reg_wdata[CORE_W-1:0];
      if (hit_top)       top_mask  <= reg_wdata[0];
      if (hit_ctrl)      msi_en    <= reg_wdata[0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_MSI_STAT:  reg_rdata = DATA_W'(msi_status);
      OFS_MSI_MASK:  reg_rdata = DATA_W'(msi_mask);
      OFS_CORE_STAT: reg_rdata = DATA_W'(core_view);
      OFS_CORE_MASK: reg_rdata = DATA_W'(core_mask);
      OFS_TOP_MASK:  reg_rdata = DATA_W'(top_mask);
      OFS_CTRL:      reg_rdata = DATA_W'(msi_en);
      default:       reg_rdata = '0;
    endcase
  end

  // R10
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(msi_mask) && $stable(core_mask) && $stable(top_mask) && $stable(msi_en));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqa_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                msi_valid,
  input  logic [VEC_W-1:0]    msi_vector,
  input  logic [CORE_SRC-1:0] core_evt,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                irq_out
);
  logic [MSI_BITS-1:0] msi_status, msi_mask, msi_clr, msi_set;
  logic [CORE_SRC-1:0] core_status, core_clr;
  logic [CORE_W-1:0]   core_mask, core_view;
  logic                top_mask, msi_en, msi_sum, core_sum;
  logic                unused_vec_hi;

  assign unused_vec_hi = ^msi_vector[VEC_W-1:SLOT_W];

  irqa_msi_fold u_fold (
    .msi_valid (msi_valid),
    .slot      (msi_vector[SLOT_W-1:0]),
    .msi_en    (msi_en),
    .set_vec   (msi_set)
  );

  irqa_status_bank #(.W(MSI_BITS)) u_msi_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(msi_set), .clr_vec(msi_clr), .status(msi_status)
  );

  irqa_status_bank #(.W(CORE_SRC)) u_core_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(core_evt), .clr_vec(core_clr), .status(core_status)
  );

  assign msi_sum   = any_open(DATA_W'(msi_status), DATA_W'(msi_mask));
  assign core_view = {msi_sum, core_status};
  assign core_sum  = any_open(DATA_W'(core_view), DATA_W'(core_mask));
  assign irq_out   = core_sum & ~top_mask;

  irqa_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .msi_status(msi_status), .core_view(core_view),
    .msi_mask(msi_mask), .core_mask(core_mask), .top_mask(top_mask), .msi_en(msi_en),
    .msi_clr(msi_clr), .core_clr(core_clr), .reg_rdata(reg_rdata)
  );

  // R2
  msi_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && msi_en) |=> msi_status[$past(msi_vector[SLOT_W-1:0])]);
  // R3
  msi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && !msi_en) |=> ((msi_status & ~$past(msi_status)) == '0));
  // R8
  core_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_evt != '0) |=> ((core_status & $past(core_evt)) == $past(core_evt)));
  // R7
  line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_status == '0 && core_status == '0) |-> !irq_out);
endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {vector, expected bit}
  localparam logic [20:0] MSI_TABLE [NVEC] = '{
    {16'h0000, 5'd0},  {16'h0004, 5'd4},  {16'hFFE4, 5'd4},  {16'h001F, 5'd31},
    {16'hFFFF, 5'd31}, {16'h0021, 5'd1},  {16'h1230, 5'd16}, {16'h8008, 5'd8}
  };

  logic clk = 0, rst_n = 0, msi_valid = 0, reg_wr = 0;
  logic [15:0] msi_vector = '0;
  logic [7:0]  core_evt = '0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq_out;
  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_vector(msi_vector),
    .core_evt(core_evt), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic send_msi(input logic [15:0] v);
    @(negedge clk); msi_valid = 1; msi_vector = v;
    @(negedge clk); msi_valid = 0;
  endtask

  task automatic pulse_core(input logic [7:0] e);
    @(negedge clk); core_evt = e;
    @(negedge clk); core_evt = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(4'd0, d); check("R1 msi status", d, 32'h0);
    rd(4'd1, d); check("R1 msi mask", d, 32'hFFFF_FFFF);
    rd(4'd2, d); check("R1 core status", d, 32'h0);
    rd(4'd3, d); check("R1 core mask", d, 32'h1FF);
    rd(4'd4, d); check("R1 top mask", d, 32'h1);
    rd(4'd5, d); check("R1 ctrl", d, 32'h0);
    check("R1 irq_out", {31'b0, irq_out}, 32'h0);

    // R3 MSI dropped while enable is off
    send_msi(16'h0004);
    rd(4'd0, d); check("R3 msi dropped", d, 32'h0);

    // open everything
    wr(4'd5, 32'h1); wr(4'd1, 32'h0); wr(4'd3, 32'h0); wr(4'd4, 32'h0);

    // R2 R7 table walk
    for (int i = 0; i < NVEC; i++) begin
      send_msi(MSI_TABLE[i][20:5]);
      rd(4'd0, d); check("R2 fold", d, 32'h1 << MSI_TABLE[i][4:0]);
      check("R7 line up", {31'b0, irq_out}, 32'h1);
      rd(4'd2, d); check("R6 msi summary bit", d, 32'h100);
      wr(4'd0, 32'hFFFF_FFFF);
      rd(4'd0, d); check("R5 w1c all", d, 32'h0);
      check("R7 line down", {31'b0, irq_out}, 32'h0);
    end

    // R2 aliasing pair
    send_msi(16'h0004); send_msi(16'hFFE4);
    rd(4'd0, d); check("R2 alias pair", d, 32'h0000_0010);

    // R5 collision: bit4 already set, clear and new event in same cycle
    @(negedge clk); reg_wr = 1; reg_addr = 4'd0; reg_wdata = 32'h10;
    msi_valid = 1; msi_vector = 16'h0024;
    @(negedge clk); reg_wr = 0; msi_valid = 0;
    rd(4'd0, d); check("R5 set wins over clear", d, 32'h10);
    wr(4'd0, 32'h10);

    // R4 each core source alone
    for (int k = 0; k < 8; k++) begin
      pulse_core(8'h1 << k);
      rd(4'd2, d); check("R4 core bit", d, 32'h1 << k);
      wr(4'd2, 32'h1 << k);
    end

    // R5 partial clear: write 0 leaves, write 1 clears
    pulse_core(8'h05);
    wr(4'd2, 32'h04);
    rd(4'd2, d); check("R5 partial w1c", d, 32'h01);
    wr(4'd2, 32'h01);

    // R8 everything masked; status still latches, line low
    wr(4'd1, 32'hFFFF_FFFF); wr(4'd3, 32'h1FF); wr(4'd4, 32'h1);
    pulse_core(8'h0B);
    send_msi(16'h0004); send_msi(16'h0005); send_msi(16'h0108);
    // R9 all visible at once
    rd(4'd2, d); check("R9 R8 core status masked", d, 32'h0B);
    rd(4'd0, d); check("R9 R8 msi status masked", d, 32'h0000_0130);
    check("R8 line masked", {31'b0, irq_out}, 32'h0);

    // R6 opening MSI mask for bit 5 only sets summary; core mask bit8 still closed
    wr(4'd1, ~32'h20);
    rd(4'd2, d); check("R6 summary via mask", d, 32'h10B);
    check("R7 core mask blocks", {31'b0, irq_out}, 32'h0);
    wr(4'd3, 32'h0FF);
    check("R7 top mask blocks", {31'b0, irq_out}, 32'h0);
    wr(4'd4, 32'h0);
    check("R7 line via msi path", {31'b0, irq_out}, 32'h1);

    // R11 bit8 read-only
    wr(4'd2, 32'h100);
    rd(4'd2, d); check("R11 summary bit ro", d, 32'h10B);

    // R10 unused offsets
    wr(4'd9, 32'hFFFF_FFFF);
    rd(4'd9, d); check("R10 unused reads 0", d, 32'h0);
    rd(4'd3, d); check("R10 unused write no effect", d, 32'h0FF);
    rd(4'd0, d); check("R10 msi status untouched", d, 32'h0000_0130);

    // R3 disable again and send a fresh vector
    wr(4'd5, 32'h0);
    send_msi(16'h0001);
    rd(4'd0, d); check("R3 dropped after disable", d, 32'h0000_0130);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule